// File: doc/BRIEF.md
# ECC Error Logging Register Block

This block sits next to a DRAM ECC checker and keeps a record of memory faults for software. The checker reports correctable (single-bit) and uncorrectable (multi-bit) faults as one-cycle pulses. Each pulse comes with the failing physical address (33 bits), the channel of the access and an 8-bit syndrome. Three more event pulses also arrive: refresh timeout, locked access to non-DRAM space and thermal sensor trip. Each event sets a sticky flag in a status register. The address, channel and syndrome of the error that matters most are held in capture registers.

Software polls through a small register port. Reads return data one cycle after the request. Writing 1 to a status flag clears it. A command register chooses which events raise the single system-error output. The capture registers keep their contents until software clears the matching status, so a read sequence spread over several cycles sees consistent data. The one exception is that an uncorrectable error replaces an earlier correctable capture.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every register reads 0 and `serr` is low.
- R2: Status bit positions are: 0 correctable, 1 uncorrectable, 8 refresh timeout, 9 locked non-DRAM access, 11 thermal. Every other status bit, and the same bits of the command register, read as 0 (mask 0x0B03). Register selects are: 0 status, 1 command, 2 address, 3 extended address, 4 syndrome. Unused selects read 0.
- R3: A status flag, once set, stays set until software writes 1 to it at select 0. Writing 0 leaves it unchanged.
- R4: An uncorrectable error arriving while no uncorrectable error is logged is captured, even over a logged correctable error or a same-cycle correctable error. The address word is {addr[31:7], six zeros, channel}, the extended word has addr[32] in bit 0 with zeros above, and the syndrome reads at select 4.
- R5: A correctable error is captured only when neither kind of error is logged. While a correctable error is logged, later correctable errors leave the capture unchanged.
- R6: While an uncorrectable error is logged, further errors of either kind leave the capture unchanged.
- R7: Once the uncorrectable flag has been cleared, the next uncorrectable error is captured again. The logged state is taken from the flags as they stood at the start of the cycle.
- R8: Refresh timeout, locked access and thermal pulses each set their own status flag and do not touch the capture registers.
- R9: `serr` is a one-cycle pulse. It fires in the first cycle a status flag reads as set, provided the command bit for that flag was already enabled. A flag that is already set does not pulse again.
- R10: When a write-1-to-clear and a new event hit the same flag in the same cycle, the flag stays set.
- R11: A read request returns data with `reg_rvalid` high exactly one cycle later, showing the register contents as of the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_evt | input | 1 | Correctable error pulse |
| ue_evt | input | 1 | Uncorrectable error pulse |
| refresh_evt | input | 1 | Refresh timeout pulse |
| lock_evt | input | 1 | Locked access to non-DRAM pulse |
| thermal_evt | input | 1 | Thermal sensor event pulse |
| evt_addr | input | 33 | Physical address of the failing access |
| evt_chan | input | 1 | Channel of the failing access |
| evt_syn | input | 8 | ECC syndrome of the failing access |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| serr | output | 1 | System-error pulse |

## Verification
The assertions assume that the address, channel and syndrome are valid in the cycle of an error pulse. They also assume that events are pulses, so a level held high is treated as a repeated event. The stimulus raises each event for exactly one cycle with its data alongside, and drops every strobe afterwards. It issues at most one write and one read per cycle, and only uses the defined selects apart from one deliberate read of an unused select.

// File: rtl/ecl_pkg.sv
package ecl_pkg;
    localparam int unsigned ST_W      = 16;
    localparam logic [15:0] ST_MASK   = 16'h0B03;
    localparam int unsigned B_CE      = 0;
    localparam int unsigned B_UE      = 1;
    localparam int unsigned B_REF     = 8;
    localparam int unsigned B_LCK     = 9;
    localparam int unsigned B_THM     = 11;
    localparam int unsigned SEL_W     = 3;
    localparam logic [2:0]  SEL_STAT  = 3'd0;
    localparam logic [2:0]  SEL_CMD   = 3'd1;
    localparam logic [2:0]  SEL_ADDR  = 3'd2;
    localparam logic [2:0]  SEL_XADDR = 3'd3;
    localparam logic [2:0]  SEL_SYN   = 3'd4;
endpackage

// File: rtl/ecl_status.sv
module ecl_status
    import ecl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] ev,
    input  logic [ST_W-1:0] clr_mask,
    input  logic            cmd_we,
    input  logic [ST_W-1:0] cmd_wdata,
    output logic [ST_W-1:0] stat,
    output logic [ST_W-1:0] cmd,
    output logic            serr
);
    typedef struct packed {
        logic [ST_W-1:0] stat;
        logic [ST_W-1:0] cmd;
        logic            serr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // set by events wins over clear
        st_d.stat = ((st_q.stat & ~clr_mask) | ev) & ST_MASK;
        if (cmd_we) begin
            st_d.cmd = cmd_wdata & ST_MASK;
        end
        st_d.serr = |(st_d.stat & ~st_q.stat & st_q.cmd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat = st_q.stat;
    assign cmd  = st_q.cmd;
    assign serr = st_q.serr;

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(st_q.stat) & ~$past(clr_mask)) & ~st_q.stat) == '0));
    p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((ev & ST_MASK) != '0) |=> ((st_q.stat & $past(ev & ST_MASK)) == $past(ev & ST_MASK)));
    p_serr_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.serr |-> ((st_q.stat & ~$past(st_q.stat) & $past(st_q.cmd)) != '0));
endmodule

// File: rtl/ecl_capture.sv
module ecl_capture #(
    parameter int unsigned PA_W  = 33,
    parameter int unsigned SYN_W = 8,
    parameter int unsigned GRAIN = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             ue,
    input  logic [PA_W-1:0]  pa,
    input  logic             ch,
    input  logic [SYN_W-1:0] syn,
    input  logic             ce_logged,
    input  logic             ue_logged,
    output logic [31:0]      addr_word,
    output logic [7:0]       xaddr_word,
    output logic [SYN_W-1:0] syn_word
);
    localparam int unsigned XB = PA_W - 32;

    typedef struct packed {
        logic [PA_W-1:GRAIN] pa;
        logic                ch;
        logic [SYN_W-1:0]    syn;
    } cap_t;

    cap_t cap_d, cap_q;
    logic take_ue, take_ce;

    always_comb begin
        take_ue = ue && !ue_logged;
        take_ce = ce && !ue && !ce_logged && !ue_logged;
        cap_d   = cap_q;
        if (take_ue || take_ce) begin
            cap_d.pa  = pa[PA_W-1:GRAIN];
            cap_d.ch  = ch;
            cap_d.syn = syn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign addr_word  = {cap_q.pa[31:GRAIN], {(GRAIN-1){1'b0}}, cap_q.ch};
    assign xaddr_word = {{(8-XB){1'b0}}, cap_q.pa[PA_W-1:32]};
    assign syn_word   = cap_q.syn;

    p_ue_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ue_logged |=> ($stable(cap_q.syn) && $stable(cap_q.pa) && $stable(cap_q.ch)));
    p_ce_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_logged && !ue) |=> ($stable(cap_q.syn) && $stable(cap_q.pa)));
    p_ue_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ue && !ue_logged) |=> (cap_q.syn == $past(syn) && cap_q.ch == $past(ch)));
endmodule

// File: rtl/ecl_regport.sv
module ecl_regport
    import ecl_pkg::*;
#(
    parameter int unsigned DW    = 32,
    parameter int unsigned SYN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd,
    input  logic [SEL_W-1:0] sel,
    input  logic [ST_W-1:0]  stat,
    input  logic [ST_W-1:0]  cmd,
    input  logic [31:0]      addr_word,
    input  logic [7:0]       xaddr_word,
    input  logic [SYN_W-1:0] syn_word,
    output logic [DW-1:0]    rdata,
    output logic             rvalid
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          vld;
    } rp_t;

    rp_t rp_d, rp_q;

    always_comb begin
        rp_d.vld  = rd;
        rp_d.data = '0;
        if (rd) begin
            case (sel)
                SEL_STAT:  rp_d.data = DW'(stat);
                SEL_CMD:   rp_d.data = DW'(cmd);
                SEL_ADDR:  rp_d.data = DW'(addr_word);
                SEL_XADDR: rp_d.data = DW'(xaddr_word);
                SEL_SYN:   rp_d.data = DW'(syn_word);
                default:   rp_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_q <= '0;
        end else begin
            rp_q <= rp_d;
        end
    end

    assign rdata  = rp_q.data;
    assign rvalid = rp_q.vld;

    p_rd_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid);
    p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rvalid);
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecl_pkg::*;
#(
    parameter int unsigned PA_W  = 33,
    parameter int unsigned SYN_W = 8,
    parameter int unsigned GRAIN = 7,
    parameter int unsigned DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_evt,
    input  logic             ue_evt,
    input  logic             refresh_evt,
    input  logic             lock_evt,
    input  logic             thermal_evt,
    input  logic [PA_W-1:0]  evt_addr,
    input  logic             evt_chan,
    input  logic [SYN_W-1:0] evt_syn,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             reg_rvalid,
    output logic             serr
);
    logic [ST_W-1:0]  ev_vec, clr_mask, stat, cmd;
    logic             cmd_we;
    logic [31:0]      addr_word;
    logic [7:0]       xaddr_word;
    logic [SYN_W-1:0] syn_word;

    always_comb begin
        ev_vec        = '0;
        ev_vec[B_CE]  = ce_evt;
        ev_vec[B_UE]  = ue_evt;
        ev_vec[B_REF] = refresh_evt;
        ev_vec[B_LCK] = lock_evt;
        ev_vec[B_THM] = thermal_evt;
        clr_mask      = '0;
        if (reg_wr && reg_sel == SEL_STAT) begin
            clr_mask = reg_wdata[ST_W-1:0] & ST_MASK;
        end
        cmd_we = reg_wr && (reg_sel == SEL_CMD);
    end

    ecl_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev_vec),
        .clr_mask  (clr_mask),
        .cmd_we    (cmd_we),
        .cmd_wdata (reg_wdata[ST_W-1:0]),
        .stat      (stat),
        .cmd       (cmd),
        .serr      (serr)
    );

    ecl_capture #(.PA_W(PA_W), .SYN_W(SYN_W), .GRAIN(GRAIN)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce         (ce_evt),
        .ue         (ue_evt),
        .pa         (evt_addr),
        .ch         (evt_chan),
        .syn        (evt_syn),
        .ce_logged  (stat[B_CE]),
        .ue_logged  (stat[B_UE]),
        .addr_word  (addr_word),
        .xaddr_word (xaddr_word),
        .syn_word   (syn_word)
    );

    ecl_regport #(.DW(DW), .SYN_W(SYN_W)) u_regport (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd         (reg_rd),
        .sel        (reg_sel),
        .stat       (stat),
        .cmd        (cmd),
        .addr_word  (addr_word),
        .xaddr_word (xaddr_word),
        .syn_word   (syn_word),
        .rdata      (reg_rdata),
        .rvalid     (reg_rvalid)
    );
endmodule

// File: tb/test_ecc_err_log.sv
`timescale 1ns/1ps
module test_ecc_err_log;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_evt = 0, ue_evt = 0, refresh_evt = 0, lock_evt = 0, thermal_evt = 0;
    logic [32:0] evt_addr = '0;
    logic        evt_chan = 0;
    logic [7:0]  evt_syn = '0;
    logic [2:0]  reg_sel = '0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid, serr;

    int n_chk = 0, n_bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 0;

    always #2 clk = ~clk;

    ecc_err_log i_ecc_err_log (
        .clk(clk), .rst_n(rst_n),
        .ce_evt(ce_evt), .ue_evt(ue_evt), .refresh_evt(refresh_evt),
        .lock_evt(lock_evt), .thermal_evt(thermal_evt),
        .evt_addr(evt_addr), .evt_chan(evt_chan), .evt_syn(evt_syn),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .serr(serr)
    );

    // monitor: pops expected read data when the design returns it
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R11 unexpected read data %h expected none", reg_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (reg_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s got %h expected %h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic rd(input logic [2:0] s, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        reg_rd = 1; reg_sel = s;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        reg_rd = 0;
    endtask

    // ev = {thermal, lock, refresh, ue, ce}
    task automatic step(input logic w, input logic [2:0] s, input logic [31:0] wd,
                        input logic [4:0] ev, input logic [32:0] a,
                        input logic ch, input logic [7:0] sy);
        @(posedge clk); #1;
        reg_wr = w; reg_sel = s; reg_wdata = wd;
        {thermal_evt, lock_evt, refresh_evt, ue_evt, ce_evt} = ev;
        evt_addr = a; evt_chan = ch; evt_syn = sy;
        @(posedge clk); #1;
        reg_wr = 0;
        {thermal_evt, lock_evt, refresh_evt, ue_evt, ce_evt} = '0;
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] wd);
        step(1'b1, s, wd, 5'b0, '0, 1'b0, 8'h0);
    endtask

    task automatic chk_serr(input logic e, input string t);
        @(negedge clk);
        n_chk++;
        if (serr !== e) begin
            n_bad++;
            $display("FAIL %s serr got %b expected %b", t, serr, e);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk_serr(1'b0, "R1 reset serr");
        rd(3'd0, 32'h0, "R1 status");
        rd(3'd1, 32'h0, "R1 command");
        rd(3'd2, 32'h0, "R1 address");
        rd(3'd4, 32'h0, "R1 syndrome");
        // R5 correctable capture
        step(0, 0, 0, 5'b00001, 33'h1_2345_67FF, 1'b1, 8'h5A);
        chk_serr(1'b0, "R9 disabled command gives no serr");
        rd(3'd0, 32'h0000_0001, "R2 status after correctable");
        rd(3'd2, 32'h2345_6781, "R4 address word format");
        rd(3'd3, 32'h0000_0001, "R4 extended address bit 32");
        rd(3'd4, 32'h0000_005A, "R5 syndrome captured");
        // R5 second correctable ignored
        step(0, 0, 0, 5'b00001, 33'h0_0000_1000, 1'b0, 8'h11);
        rd(3'd2, 32'h2345_6781, "R5 second correctable address held");
        rd(3'd4, 32'h0000_005A, "R5 second correctable syndrome held");
        // R4 uncorrectable overwrites correctable
        step(0, 0, 0, 5'b00010, 33'h0_ABCD_EF00, 1'b0, 8'hC3);
        rd(3'd0, 32'h0000_0003, "R4 status both flags");
        rd(3'd2, 32'hABCD_EF00, "R4 overwrite address");
        rd(3'd3, 32'h0000_0000, "R4 overwrite extended");
        rd(3'd4, 32'h0000_00C3, "R4 overwrite syndrome");
        // R6 later errors ignored while uncorrectable logged
        step(0, 0, 0, 5'b00010, 33'h1_0000_0080, 1'b1, 8'h77);
        step(0, 0, 0, 5'b00001, 33'h1_0000_0100, 1'b1, 8'h66);
        rd(3'd2, 32'hABCD_EF00, "R6 address held");
        rd(3'd4, 32'h0000_00C3, "R6 syndrome held");
        // R3 write-1-to-clear
        wr(3'd0, 32'h0000_0001);
        rd(3'd0, 32'h0000_0002, "R3 clear correctable only");
        wr(3'd0, 32'h0000_0000);
        rd(3'd0, 32'h0000_0002, "R3 write 0 keeps flag");
        wr(3'd0, 32'h0000_0002);
        rd(3'd0, 32'h0000_0000, "R3 clear uncorrectable");
        // R7 recapture after clear
        step(0, 0, 0, 5'b00010, 33'h1_FFFF_FFFF, 1'b1, 8'hEE);
        rd(3'd2, 32'hFFFF_FF81, "R7 recapture address");
        rd(3'd3, 32'h0000_0001, "R7 recapture extended");
        rd(3'd4, 32'h0000_00EE, "R7 recapture syndrome");
        wr(3'd0, 32'h0000_0B03);
        // R4 simultaneous correctable and uncorrectable
        step(0, 0, 0, 5'b00011, 33'h0_0000_0380, 1'b0, 8'h3C);
        rd(3'd0, 32'h0000_0003, "R4 simultaneous status");
        rd(3'd4, 32'h0000_003C, "R4 simultaneous syndrome");
        wr(3'd0, 32'h0000_0B03);
        // R8 other events
        step(0, 0, 0, 5'b11100, 33'h0_1111_1100, 1'b1, 8'h99);
        rd(3'd0, 32'h0000_0B00, "R8 other events set flags");
        rd(3'd4, 32'h0000_003C, "R8 capture untouched");
        // R2 reserved bits
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, 32'h0000_0B03, "R2 command reserved bits zero");
        rd(3'd6, 32'h0000_0000, "R2 unused select reads 0");
        // R9 serr pulse
        wr(3'd1, 32'h0000_0800);
        wr(3'd0, 32'h0000_0B03);
        rd(3'd0, 32'h0000_0000, "R3 all cleared");
        step(0, 0, 0, 5'b00100, '0, 1'b0, 8'h0);
        chk_serr(1'b0, "R9 disabled refresh no serr");
        step(0, 0, 0, 5'b10000, '0, 1'b0, 8'h0);
        chk_serr(1'b1, "R9 thermal serr pulse");
        chk_serr(1'b0, "R9 serr one cycle");
        step(0, 0, 0, 5'b10000, '0, 1'b0, 8'h0);
        chk_serr(1'b0, "R9 already set no pulse");
        // R10 event wins over clear
        step(1, 3'd0, 32'h0000_0100, 5'b00100, '0, 1'b0, 8'h0);
        rd(3'd0, 32'h0000_0900, "R10 event beats clear");
        wr(3'd0, 32'h0000_0100);
        rd(3'd0, 32'h0000_0800, "R10 later clear works");
        repeat (4) @(posedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R11 missing reads got %0d expected 0", exp_q.size());
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule